// File: doc/BRIEF.md
# Translation Lookaside Buffer with Invalidation

A small fully associative store of recently used virtual-to-physical translations, placed in front of a page table walker. A lookup presents a virtual address. In the same cycle the block answers either with a hit or with a miss. A hit carries the physical address, the page size and the stored permission and state bits. A miss tells the walker to fetch the mapping from the tables. A hit saves the whole multi-read table walk.

When the walker finishes, it writes the result in through the fill port. Entries are never updated when page table memory changes. They leave the buffer only on explicit commands: a single-page invalidate, or an address-space switch. The switch clears every entry except those flagged global. Each entry maps a 4 KiB, 2 MiB or 1 GiB page, so one entry can cover a large region.

Top module: `tlb_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses until a fill has been written.
- R2: `lk_hit` and `lk_miss` are combinational in the lookup cycle and never both high. With `lk_valid` low, both stay low. On a miss, `lk_paddr`, `lk_size` and the four attribute outputs are zero.
- R3: On a hit the block returns the stored page size and the stored writable, user, no-execute and dirty bits. The physical address is the frame base (`{frame number, 12 zero bits}`) with its low offset bits replaced by the lookup address.
- R4: The size code decides how many low address bits the match ignores and how many are passed through as offset. Code 0 means 4 KiB: 12 bits ignored and passed. Code 1 means 2 MiB: 21 bits. Code 2 means 1 GiB: 30 bits. The frame number is masked to the same alignment when stored.
- R5: A fill that overlaps no live entry is written to the lowest-numbered free slot. The fill becomes visible to lookups from the next cycle.
- R6: When every slot is live, a non-overlapping fill replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset, advances by one only on such a replacement, and wraps from the last slot to 0.
- R7: A fill overlaps an entry when the two agree on all page bits above the coarser of their two sizes. The fill is written into the lowest overlapping slot, and all other overlapping entries are removed. At most one entry can hit any address.
- R8: A page invalidate removes every entry whose page covers the given virtual page. Other entries are kept.
- R9: An invalidate or address-space switch in the same cycle as a lookup takes effect before that lookup.
- R10: An address-space switch removes every entry whose global flag is clear and keeps the global ones.
- R11: A fill in the same cycle as an invalidate or switch is applied after it, so the new entry survives.
- R12: Size code 3 is treated as a 4 KiB page and is reported back as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup found nothing; a walk is needed |
| lk_paddr | output | PA_W | Translated physical address |
| lk_size | output | 2 | Page size code of the hit entry |
| lk_wr | output | 1 | Writable bit of the hit entry |
| lk_user | output | 1 | User-access bit of the hit entry |
| lk_nx | output | 1 | No-execute bit of the hit entry |
| lk_dirty | output | 1 | Recorded dirty state of the hit entry |
| fill_valid | input | 1 | Write a translation from the walker |
| fill_vpage | input | VA_W-12 | Virtual page number of the fill |
| fill_size | input | 2 | Page size code of the fill |
| fill_pfn | input | PA_W-12 | Physical frame number (4 KiB units) |
| fill_wr | input | 1 | Merged writable permission |
| fill_user | input | 1 | Merged user permission |
| fill_nx | input | 1 | Merged no-execute bit |
| fill_global | input | 1 | Entry survives address-space switches |
| fill_dirty | input | 1 | Dirty state already recorded for the page |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpage | input | VA_W-12 | Virtual page number to invalidate |
| as_switch | input | 1 | Address-space switch: drop non-global entries |

## Verification
The bench builds the block with ENTRIES=4, VA_W=48 and PA_W=40. With only four slots, a few fills fill the buffer, drive round-robin replacement through a full wrap of the pointer, and mix free-slot and pointer-chosen placement. The 40-bit physical width still leaves room for 2 MiB and 1 GiB frames, so offset pass-through can be checked at all three sizes. Overlap merging, same-cycle invalidate-before-lookup and fills issued alongside a switch or an invalidate are driven as directed cases.

// File: rtl/tlb_cache.sv
module tlb_cache #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [1:0]        lk_size,
  output logic              lk_wr,
  output logic              lk_user,
  output logic              lk_nx,
  output logic              lk_dirty,
  input  logic              fill_valid,
  input  logic [VA_W-13:0]  fill_vpage,
  input  logic [1:0]        fill_size,
  input  logic [PA_W-13:0]  fill_pfn,
  input  logic              fill_wr,
  input  logic              fill_user,
  input  logic              fill_nx,
  input  logic              fill_global,
  input  logic              fill_dirty,
  input  logic              inv_valid,
  input  logic [VA_W-13:0]  inv_vpage,
  input  logic              as_switch
);
  localparam int VPN_W = VA_W - 12;
  localparam int PFN_W = PA_W - 12;
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [1:0] norm_sz(input logic [1:0] s);
    return (s == 2'd3) ? 2'd0 : s;
  endfunction

  function automatic logic [VPN_W-1:0] vpn_keep(input logic [1:0] s);
    logic [VPN_W-1:0] m = '1;
    if (s == 2'd1) m[8:0] = '0;
    else if (s == 2'd2) m[17:0] = '0;
    return m;
  endfunction

  function automatic logic [PFN_W-1:0] pfn_keep(input logic [1:0] s);
    logic [PFN_W-1:0] m = '1;
    if (s == 2'd1) m[8:0] = '0;
    else if (s == 2'd2) m[17:0] = '0;
    return m;
  endfunction

  function automatic logic [PA_W-1:0] off_mask(input logic [1:0] s);
    logic [PA_W-1:0] m = '0;
    m[11:0] = '1;
    if (s == 2'd1) m[20:0] = '1;
    else if (s == 2'd2) m[29:0] = '1;
    return m;
  endfunction

  logic [ENTRIES-1:0] v_q, g_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [1:0]         sz_q   [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [3:0]         attr_q [ENTRIES];
  logic [IW-1:0]      rr_q;

  logic [VPN_W-1:0]   lk_vpn;
  logic [1:0]         f_sz;
  assign lk_vpn = lk_vaddr[VA_W-1:12];
  assign f_sz   = norm_sz(fill_size);

  logic [ENTRIES-1:0] kill, v_live, hit_vec, ovl;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      kill[i]    = (inv_valid && (((inv_vpage ^ tag_q[i]) & vpn_keep(sz_q[i])) == '0))
                   || (as_switch && !g_q[i]);
      v_live[i]  = v_q[i] && !kill[i];
      hit_vec[i] = lk_valid && v_live[i]
                   && (((lk_vpn ^ tag_q[i]) & vpn_keep(sz_q[i])) == '0);
      ovl[i]     = v_live[i]
                   && (((fill_vpage ^ tag_q[i]) & vpn_keep(sz_q[i]) & vpn_keep(f_sz)) == '0);
    end
  end

  logic [IW-1:0] ovl_idx, free_idx, victim;
  logic          any_ovl, any_free;

  always_comb begin
    ovl_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ovl[i])     ovl_idx  = IW'(i);
      if (!v_live[i]) free_idx = IW'(i);
    end
  end

  assign any_ovl  = |ovl;
  assign any_free = ~&v_live;
  assign victim   = any_ovl ? ovl_idx : (any_free ? free_idx : rr_q);

  logic [PFN_W-1:0] r_pfn;
  logic [1:0]       r_sz;
  logic [3:0]       r_attr;

  always_comb begin
    r_pfn  = '0;
    r_sz   = '0;
    r_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        r_pfn  = r_pfn  | pfn_q[i];
        r_sz   = r_sz   | sz_q[i];
        r_attr = r_attr | attr_q[i];
      end
    end
  end

  logic [PA_W-1:0] om;
  assign om       = off_mask(r_sz);
  assign lk_hit   = |hit_vec;
  assign lk_miss  = lk_valid && !lk_hit;
  assign lk_paddr = lk_hit ? (({r_pfn, 12'h000} & ~om) | (PA_W'(lk_vaddr[29:0]) & om)) : '0;
  assign lk_size  = r_sz;
  assign {lk_wr, lk_user, lk_nx, lk_dirty} = r_attr;

  logic [ENTRIES-1:0] v_next;
  always_comb begin
    v_next = v_live;
    if (fill_valid) begin
      v_next         = v_live & ~ovl;
      v_next[victim] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      rr_q <= '0;
    end else begin
      v_q <= v_next;
      if (fill_valid && !any_ovl && !any_free)
        rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_q[victim]  <= fill_vpage & vpn_keep(f_sz);
      sz_q[victim]   <= f_sz;
      pfn_q[victim]  <= fill_pfn & pfn_keep(f_sz);
      attr_q[victim] <= {fill_wr, fill_user, fill_nx, fill_dirty};
      g_q[victim]    <= fill_global;
    end
  end
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [VA_W-13:0]   lk_vpn,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] v_q,
  input logic [ENTRIES-1:0] g_q,
  input logic               fill_valid,
  input logic [VA_W-13:0]   fill_vpage,
  input logic               inv_valid,
  input logic [VA_W-13:0]   inv_vpage,
  input logic               as_switch
);
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (v_q == '0));

  p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  p_fill_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !inv_valid && !as_switch) |=>
      (!(lk_valid && !inv_valid && !as_switch && lk_vpn == $past(fill_vpage)) || lk_hit));

  p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_inv_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !fill_valid) |=>
      (!(lk_valid && lk_vpn == $past(inv_vpage)) || !lk_hit));

  p_inv_before_lookup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && lk_valid && lk_vpn == inv_vpage) |-> !lk_hit);

  p_switch_keeps_global_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (as_switch && !fill_valid) |=> ((v_q & ~g_q) == '0));
endmodule

bind tlb_cache tlb_cache_chk #(.ENTRIES(ENTRIES), .VA_W(VA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_vpn     (lk_vaddr[VA_W-1:12]),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .hit_vec    (hit_vec),
  .v_q        (v_q),
  .g_q        (g_q),
  .fill_valid (fill_valid),
  .fill_vpage (fill_vpage),
  .inv_valid  (inv_valid),
  .inv_vpage  (inv_vpage),
  .as_switch  (as_switch)
);

// File: tb/tlb_cache_test.sv
module tlb_cache_test;
  localparam int N  = 4;
  localparam int VW = 48;
  localparam int PW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [VW-1:0] lk_vaddr = '0;
  logic lk_hit, lk_miss, lk_wr, lk_user, lk_nx, lk_dirty;
  logic [PW-1:0] lk_paddr;
  logic [1:0] lk_size;
  logic fill_valid = 1'b0;
  logic [VW-13:0] fill_vpage = '0;
  logic [1:0] fill_size = '0;
  logic [PW-13:0] fill_pfn = '0;
  logic fill_wr = 1'b0, fill_user = 1'b0, fill_nx = 1'b0, fill_global = 1'b0, fill_dirty = 1'b0;
  logic inv_valid = 1'b0;
  logic [VW-13:0] inv_vpage = '0;
  logic as_switch = 1'b0;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  tlb_cache #(.ENTRIES(N), .VA_W(VW), .PA_W(PW)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_size(lk_size),
    .lk_wr(lk_wr), .lk_user(lk_user), .lk_nx(lk_nx), .lk_dirty(lk_dirty),
    .fill_valid(fill_valid), .fill_vpage(fill_vpage), .fill_size(fill_size),
    .fill_pfn(fill_pfn), .fill_wr(fill_wr), .fill_user(fill_user), .fill_nx(fill_nx),
    .fill_global(fill_global), .fill_dirty(fill_dirty),
    .inv_valid(inv_valid), .inv_vpage(inv_vpage), .as_switch(as_switch)
  );

  localparam int NV = 8;
  localparam logic [VW-1:0] VT_VA [NV] = '{48'h0000_0040_1abc, 48'h0000_0040_2000,
    48'h0000_8023_4567, 48'h0000_803f_ffff, 48'h0000_8040_0000,
    48'h0000_c123_4567, 48'h0000_ffff_ffff, 48'h0001_0000_0000};
  localparam logic VT_HIT [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [PW-1:0] VT_PA [NV] = '{40'h12_3abc, 40'h0, 40'h43_4567, 40'h5f_ffff,
    40'h0, 40'h4123_4567, 40'h7fff_ffff, 40'h0};
  localparam logic [1:0] VT_SZ [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd2, 2'd2, 2'd0};
  localparam logic [3:0] VT_AT [NV] = '{4'b1000, 4'b0, 4'b0101, 4'b0101, 4'b0,
    4'b1010, 4'b1010, 4'b0};

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic fill(input logic [VW-1:0] va, input logic [1:0] sz, input logic [PW-13:0] pfn,
                      input logic [3:0] at, input logic g);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpage = va[VW-1:12]; fill_size = sz; fill_pfn = pfn;
    {fill_wr, fill_user, fill_nx, fill_dirty} = at; fill_global = g;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic inv(input logic [VW-1:0] va);
    @(negedge clk);
    inv_valid = 1'b1; inv_vpage = va[VW-1:12];
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic look(input string rq, input logic [VW-1:0] va, input logic eh,
                      input logic [PW-1:0] epa, input logic [1:0] esz, input logic [3:0] eat);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va;
    #1;
    check(rq, 64'({lk_hit, lk_miss}), 64'({eh, !eh}));
    if (eh) check(rq, 64'({lk_paddr, lk_size, lk_wr, lk_user, lk_nx, lk_dirty}),
                  64'({epa, esz, eat}));
    else check(rq, 64'({lk_paddr, lk_size, lk_wr, lk_user, lk_nx, lk_dirty}), 64'(0));
    lk_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: lookups during and right after reset miss
    lk_valid = 1'b1; lk_vaddr = 48'h401abc;
    repeat (3) @(negedge clk);
    #1 check("R1 in reset", 64'({lk_hit, lk_miss}), 64'(2'b01));
    lk_valid = 1'b0;
    rst_n = 1'b1;
    look("R1 empty", 48'h401abc, 1'b0, '0, '0, '0);

    // R5/R3/R4: three sizes in slots 0..2, then walk the vector table
    fill(48'h0000_0040_1000, 2'd0, 28'h123,   4'b1000, 1'b0);
    fill(48'h0000_8020_0000, 2'd1, 28'h400,   4'b0101, 1'b0);
    fill(48'h0000_c000_0000, 2'd2, 28'h40000, 4'b1010, 1'b1);
    for (int k = 0; k < NV; k++)
      look($sformatf("R3 R4 vec%0d", k), VT_VA[k], VT_HIT[k], VT_PA[k], VT_SZ[k], VT_AT[k]);

    // R2: idle lookup port stays quiet even over a mapped address
    @(negedge clk);
    lk_valid = 1'b0; lk_vaddr = 48'h401abc;
    #1 check("R2 idle", 64'({lk_hit, lk_miss}), 64'(0));

    // R8: invalidate inside the 2 MiB page removes it, 4 KiB entry kept
    inv(48'h0000_8030_0000);
    look("R8 removed", 48'h0000_8023_4567, 1'b0, '0, '0, '0);
    look("R8 kept", 48'h401abc, 1'b1, 40'h12_3abc, 2'd0, 4'b1000);

    // R9: invalidate in the lookup cycle wins
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = 48'h401abc; inv_valid = 1'b1; inv_vpage = 36'h401;
    #1 check("R9 same cycle", 64'({lk_hit, lk_miss}), 64'(2'b01));
    @(negedge clk);
    inv_valid = 1'b0; lk_valid = 1'b0;
    look("R9 after", 48'h401abc, 1'b0, '0, '0, '0);

    // R10: switch keeps global entries only
    fill(48'h0000_0040_1000, 2'd0, 28'h123, 4'b1000, 1'b0);
    fill(48'h0000_0000_7000, 2'd0, 28'h777, 4'b0000, 1'b1);
    @(negedge clk); as_switch = 1'b1;
    @(negedge clk); as_switch = 1'b0;
    look("R10 non-global gone", 48'h401abc, 1'b0, '0, '0, '0);
    look("R10 global 1G kept", 48'h0000_c123_4567, 1'b1, 40'h4123_4567, 2'd2, 4'b1010);
    look("R10 global 4K kept", 48'h7abc, 1'b1, 40'h77_7abc, 2'd0, 4'b0000);

    // R1 again, then R5/R6 round-robin replacement
    do_reset();
    look("R1 cleared", 48'h7abc, 1'b0, '0, '0, '0);
    for (int k = 0; k < 4; k++)
      fill(48'h10000 + 48'(k) * 48'h1000, 2'd0, 28'h100 + 28'(k), 4'b0, 1'b0);
    for (int k = 0; k < 4; k++)
      look("R5 fill", 48'h10000 + 48'(k) * 48'h1000, 1'b1, 40'(28'h100 + 28'(k)) << 12, 2'd0, 4'b0);
    fill(48'h14000, 2'd0, 28'h104, 4'b0, 1'b0);
    look("R6 slot0 evicted", 48'h10000, 1'b0, '0, '0, '0);
    look("R6 slot1 kept", 48'h11000, 1'b1, 40'h10_1000, 2'd0, 4'b0);
    fill(48'h15000, 2'd0, 28'h105, 4'b0, 1'b0);
    look("R6 slot1 evicted", 48'h11000, 1'b0, '0, '0, '0);
    look("R6 slot2 kept", 48'h12000, 1'b1, 40'h10_2000, 2'd0, 4'b0);
    inv(48'h13000);
    fill(48'h16000, 2'd0, 28'h106, 4'b0, 1'b0);
    fill(48'h17000, 2'd0, 28'h107, 4'b0, 1'b0);
    look("R6 pointer held over free fill", 48'h12000, 1'b0, '0, '0, '0);
    look("R5 free slot used", 48'h16000, 1'b1, 40'h10_6000, 2'd0, 4'b0);
    look("R6 newest", 48'h17000, 1'b1, 40'h10_7000, 2'd0, 4'b0);

    // R7: a 2 MiB fill absorbs all four 4 KiB entries
    fill(48'h0, 2'd1, 28'h800, 4'b1001, 1'b0);
    look("R7 merged", 48'h15123, 1'b1, 40'h81_5123, 2'd1, 4'b1001);
    look("R7 merged other", 48'h17fff, 1'b1, 40'h81_7fff, 2'd1, 4'b1001);
    fill(48'h40_0000, 2'd0, 28'h9, 4'b0, 1'b0);
    fill(48'h60_0000, 2'd0, 28'ha, 4'b0, 1'b0);
    fill(48'ha0_0000, 2'd0, 28'hb, 4'b0, 1'b0);
    fill(48'hc0_0000, 2'd0, 28'hc, 4'b0, 1'b0);
    look("R6 pointer at 3", 48'ha0_0000, 1'b0, '0, '0, '0);
    look("R6 slot1 kept", 48'h40_0123, 1'b1, 40'h9123, 2'd0, 4'b0);
    fill(48'h100_0000, 2'd0, 28'hd, 4'b0, 1'b0);
    look("R6 wrap to slot0", 48'h15123, 1'b0, '0, '0, '0);
    look("R6 wrap newest", 48'h100_0040, 1'b1, 40'hd040, 2'd0, 4'b0);

    // R11: fill alongside a switch, then alongside an invalidate of itself
    @(negedge clk);
    as_switch = 1'b1; fill_valid = 1'b1; fill_vpage = 36'he00; fill_size = 2'd0;
    fill_pfn = 28'hee; {fill_wr, fill_user, fill_nx, fill_dirty} = 4'b0; fill_global = 1'b0;
    @(negedge clk);
    as_switch = 1'b0; fill_valid = 1'b0;
    look("R11 fill survives switch", 48'he0_0010, 1'b1, 40'hee010, 2'd0, 4'b0);
    look("R11 old entries gone", 48'h40_0123, 1'b0, '0, '0, '0);
    @(negedge clk);
    inv_valid = 1'b1; inv_vpage = 36'he00; fill_valid = 1'b1; fill_pfn = 28'hef;
    @(negedge clk);
    inv_valid = 1'b0; fill_valid = 1'b0;
    look("R11 fill survives invalidate", 48'he0_0010, 1'b1, 40'hef010, 2'd0, 4'b0);

    // R12: size code 3 acts as 4 KiB
    fill(48'h2_0000_0000, 2'd3, 28'h55, 4'b0100, 1'b0);
    look("R12 in page", 48'h2_0000_0fff, 1'b1, 40'h55fff, 2'd0, 4'b0100);
    look("R12 next page", 48'h2_0000_1000, 1'b0, '0, '0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule